// File: doc/BRIEF.md
# I2C Target Receive Byte Queue

This block buffers the bytes that an I2C target's bit-level engine receives and decides how that engine answers a controller. The engine signals each address match for a write transfer, each received data byte, and each end of transfer. The block then returns an ACK or NACK decision at once, in the same cycle. Accepted bytes go into an eight-entry first-in first-out queue. Software drains the queue one byte at a time through a read strobe.

When a new write transfer starts while bytes from an earlier transfer are still unread, a policy input selects the response. With the policy low, the address is accepted and every data byte of that transfer is refused. With the policy high, the address itself is refused. The block also drives three flags. The first is a level flag that compares the occupancy against a programmable threshold. The second is a sticky overflow flag with a gated interrupt. The third is a busy indication for a one-cycle queue flush.

Top module: `i2c_tgt_rxq`

## Requirements
- R1: After reset the queue holds zero bytes, `level_o` reads 0, and `depth_o` always reads 8. The occupancy never exceeds 8.
- R2: `thr_flag_o` is 1 exactly when `level_o` is greater than or equal to the 4-bit value on `thresh_i`.
- R3: With `thresh_i` = 0 the level flag is 1 even when the queue is empty. With `thresh_i` = 8 it is 1 only when the queue is full. With a value of 9 to 15 it stays 0.
- R4: A cycle with `flush_wr_i` = 1 makes `flush_busy_o` read 1 in the next cycle. At the end of that busy cycle all stored bytes are gone and `flush_busy_o` returns to 0. A cycle with `flush_wr_i` = 0 starts nothing.
- R5: If `wr_req_i` arrives while the queue holds data and `dnr_i` = 0, then `addr_ack_o` = 1. Every data byte until `stop_i` gets `byte_ack_o` = 0 and is not stored.
- R6: If `wr_req_i` arrives while the queue holds data and `dnr_i` = 1, then `addr_ack_o` = 0 in that cycle.
- R7: If `wr_req_i` arrives with the queue empty, then `addr_ack_o` = 1 whatever `dnr_i` is. Each following data byte is stored and acknowledged with `byte_ack_o` = 1 while there is room.
- R8: A data byte outside a refused transfer that arrives while the queue holds 8 bytes is discarded and gets `byte_ack_o` = 0. It also sets `ovf_o`, which stays 1 until a cycle with `ovf_clr_i` = 1 and no new overflow.
- R9: `ovf_irq_o` equals `ovf_o` when `ovf_ie_i` = 1, and is 0 when `ovf_ie_i` = 0. The enable comes out of reset at 0.
- R10: With the queue empty, `rd_data_o` reads 0 and a `rd_i` strobe leaves the occupancy unchanged.
- R11: `rd_data_o` shows the oldest stored byte. Each `rd_i` strobe on a non-empty queue removes it, so bytes leave in arrival order.
- R12: A data byte arriving during the busy cycle of a flush is dropped, gets `byte_ack_o` = 0 and does not set `ovf_o`. A read strobe in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req_i | input | 1 | Pulse: address matched for a write transfer |
| stop_i | input | 1 | Pulse: current transfer ended |
| byte_vld_i | input | 1 | Pulse: a data byte was received |
| byte_i | input | 8 | Received data byte |
| addr_ack_o | output | 1 | 1 = acknowledge the address in this cycle |
| byte_ack_o | output | 1 | 1 = acknowledge (and store) the data byte in this cycle |
| rd_i | input | 1 | Software read strobe, removes the oldest byte |
| rd_data_o | output | 8 | Oldest stored byte, 0 when empty |
| level_o | output | 4 | Number of stored bytes |
| depth_o | output | 8 | Queue capacity, constant 8 |
| thresh_i | input | 4 | Level threshold |
| thr_flag_o | output | 1 | Occupancy at or above threshold |
| flush_wr_i | input | 1 | Write-one strobe that starts a flush |
| flush_busy_o | output | 1 | Flush in progress |
| dnr_i | input | 1 | Policy: 1 = refuse address, 0 = refuse data, when unread data remains |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ovf_clr_i | input | 1 | Write-one strobe that clears the overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_irq_o | output | 1 | Gated overflow interrupt |

## Verification
The hardest cases to reach are the collisions. One is a data byte that lands in the busy cycle of a flush. Another is a fresh write request that comes while a previous transfer's bytes are still unread, since that state depends on how software and the engine interleave. The directed part of the stimulus builds each collision on purpose. It fills the queue completely and then pushes past it, and it starts a second transfer without reading, once under each policy. It also times a byte and a read to coincide with the flush busy cycle. A long randomized phase then mixes requests, stops, bytes, reads, flushes and threshold changes with weights that keep the queue near both empty and full. A queue-based model predicts every output on every cycle.

// File: rtl/i2c_rxq_pkg.sv
package i2c_rxq_pkg;

    localparam int RXQ_DEPTH  = 8;
    localparam int RXQ_DATA_W = 8;
    localparam int RXQ_TH_W   = 4;
    localparam int RXQ_CNT_W  = $clog2(RXQ_DEPTH + 1);

    // Transfer state kept between an address match and the end of transfer
    typedef enum logic [1:0] {
        SES_IDLE  = 2'd0,
        SES_OPEN  = 2'd1,
        SES_BLOCK = 2'd2
    } ses_e;

    // Response decision handed back to the bit engine
    typedef struct packed {
        logic addr_ack;
        logic byte_ack;
    } resp_t;

    // Flag bundle
    typedef struct packed {
        logic thr;
        logic ovf;
        logic irq;
    } flags_t;

    function automatic logic level_reached(input logic [RXQ_CNT_W-1:0] lvl,
                                           input logic [RXQ_TH_W-1:0]  th);
        return ({{(RXQ_TH_W > RXQ_CNT_W ? RXQ_TH_W - RXQ_CNT_W : 0){1'b0}}, lvl} >= th);
    endfunction

endpackage

// File: rtl/i2c_rxq_store.sv
module i2c_rxq_store
    import i2c_rxq_pkg::*;
#(
    parameter int DEPTH  = RXQ_DEPTH,
    parameter int DATA_W = RXQ_DATA_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             push_i,
    input  logic [DATA_W-1:0]                din_i,
    input  logic                             pop_i,
    input  logic                             flush_req_i,
    output logic                             busy_o,
    output logic [DATA_W-1:0]                dout_o,
    output logic [$clog2(DEPTH+1)-1:0]       count_o,
    output logic                             empty_o,
    output logic                             full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp, wp_nxt, rp_nxt;
    logic [CW-1:0]     cnt;
    logic              busy_q;
    logic              do_push, do_pop;

    assign empty_o = (cnt == '0);
    assign full_o  = (cnt == CW'(DEPTH));
    assign do_push = push_i && !full_o && !busy_q;
    assign do_pop  = pop_i && !empty_o && !busy_q;
    assign wp_nxt  = (wp == LAST) ? '0 : wp + 1'b1;
    assign rp_nxt  = (rp == LAST) ? '0 : rp + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp     <= '0;
            rp     <= '0;
            cnt    <= '0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= flush_req_i;
            if (busy_q) begin
                wp  <= '0;
                rp  <= '0;
                cnt <= '0;
            end else begin
                if (do_push) wp <= wp_nxt;
                if (do_pop)  rp <= rp_nxt;
                cnt <= cnt + CW'(do_push) - CW'(do_pop);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din_i;
    end

    assign dout_o  = empty_o ? '0 : mem[rp];
    assign count_o = cnt;
    assign busy_o  = busy_q;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    p_flush_clears_r4: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> (cnt == '0));

    p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty_o && !push_i) |=> $stable(cnt));

    p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (full_o && !pop_i && !busy_q) |=> full_o);

endmodule

// File: rtl/i2c_rxq_policy.sv
module i2c_rxq_policy
    import i2c_rxq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_req_i,
    input  logic  stop_i,
    input  logic  byte_vld_i,
    input  logic  dnr_i,
    input  logic  empty_i,
    input  logic  full_i,
    input  logic  busy_i,
    output resp_t resp_o,
    output logic  push_o,
    output logic  ovf_evt_o
);
    ses_e ses_q;
    logic open_path;

    always_ff @(posedge clk) begin
        if (rst) begin
            ses_q <= SES_IDLE;
        end else if (wr_req_i) begin
            ses_q <= empty_i ? SES_OPEN : SES_BLOCK;
        end else if (stop_i) begin
            ses_q <= SES_IDLE;
        end
    end

    assign open_path = byte_vld_i && (ses_q != SES_BLOCK) && !busy_i;
    assign push_o    = open_path && !full_i;
    assign ovf_evt_o = open_path && full_i;

    always_comb begin
        resp_o          = '0;
        resp_o.addr_ack = wr_req_i && (empty_i || !dnr_i);
        resp_o.byte_ack = push_o;
    end

    p_blk_data_nack_r5: assert property (@(posedge clk) disable iff (rst)
        (ses_q == SES_BLOCK && byte_vld_i) |-> !resp_o.byte_ack);

    p_addr_nack_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req_i && dnr_i && !empty_i) |-> !resp_o.addr_ack);

    p_empty_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_req_i && empty_i) |-> resp_o.addr_ack);

    p_flush_drop_r12: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> (!push_o && !ovf_evt_o));

endmodule

// File: rtl/i2c_rxq_flags.sv
module i2c_rxq_flags
    import i2c_rxq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RXQ_CNT_W-1:0] level_i,
    input  logic [RXQ_TH_W-1:0]  thresh_i,
    input  logic                 ovf_evt_i,
    input  logic                 ovf_clr_i,
    input  logic                 ovf_ie_i,
    output flags_t               flags_o
);
    logic ovf_q;

    always_ff @(posedge clk) begin
        if (rst)            ovf_q <= 1'b0;
        else if (ovf_evt_i) ovf_q <= 1'b1;
        else if (ovf_clr_i) ovf_q <= 1'b0;
    end

    always_comb begin
        flags_o     = '0;
        flags_o.thr = level_reached(level_i, thresh_i);
        flags_o.ovf = ovf_q;
        flags_o.irq = ovf_q && ovf_ie_i;
    end

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr_i) |=> ovf_q);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        flags_o.irq |-> ovf_ie_i);

    p_thr_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (thresh_i == '0) |-> flags_o.thr);

endmodule

// File: rtl/i2c_tgt_rxq.sv
module i2c_tgt_rxq
    import i2c_rxq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_req_i,
    input  logic                  stop_i,
    input  logic                  byte_vld_i,
    input  logic [RXQ_DATA_W-1:0] byte_i,
    output logic                  addr_ack_o,
    output logic                  byte_ack_o,
    input  logic                  rd_i,
    output logic [RXQ_DATA_W-1:0] rd_data_o,
    output logic [RXQ_CNT_W-1:0]  level_o,
    output logic [7:0]            depth_o,
    input  logic [RXQ_TH_W-1:0]   thresh_i,
    output logic                  thr_flag_o,
    input  logic                  flush_wr_i,
    output logic                  flush_busy_o,
    input  logic                  dnr_i,
    input  logic                  ovf_ie_i,
    input  logic                  ovf_clr_i,
    output logic                  ovf_o,
    output logic                  ovf_irq_o
);
    logic   push, ovf_evt, empty, full, busy;
    resp_t  resp;
    flags_t flags;
    logic [RXQ_CNT_W-1:0] level;

    i2c_rxq_store #(.DEPTH(RXQ_DEPTH), .DATA_W(RXQ_DATA_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push),
        .din_i       (byte_i),
        .pop_i       (rd_i),
        .flush_req_i (flush_wr_i),
        .busy_o      (busy),
        .dout_o      (rd_data_o),
        .count_o     (level),
        .empty_o     (empty),
        .full_o      (full)
    );

    i2c_rxq_policy u_policy (
        .clk        (clk),
        .rst        (rst),
        .wr_req_i   (wr_req_i),
        .stop_i     (stop_i),
        .byte_vld_i (byte_vld_i),
        .dnr_i      (dnr_i),
        .empty_i    (empty),
        .full_i     (full),
        .busy_i     (busy),
        .resp_o     (resp),
        .push_o     (push),
        .ovf_evt_o  (ovf_evt)
    );

    i2c_rxq_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .level_i   (level),
        .thresh_i  (thresh_i),
        .ovf_evt_i (ovf_evt),
        .ovf_clr_i (ovf_clr_i),
        .ovf_ie_i  (ovf_ie_i),
        .flags_o   (flags)
    );

    assign addr_ack_o   = resp.addr_ack;
    assign byte_ack_o   = resp.byte_ack;
    assign level_o      = level;
    assign depth_o      = 8'(RXQ_DEPTH);
    assign thr_flag_o   = flags.thr;
    assign flush_busy_o = busy;
    assign ovf_o        = flags.ovf;
    assign ovf_irq_o    = flags.irq;

    p_ovf_needs_full_r8: assert property (@(posedge clk) disable iff (rst)
        (!ovf_o ##1 ovf_o) |-> $past(full));

endmodule

// File: tb/sim_i2c_tgt_rxq.sv
module sim_i2c_tgt_rxq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_req_i = 0, stop_i = 0, byte_vld_i = 0, rd_i = 0;
    logic [7:0] byte_i = '0;
    logic [3:0] thresh_i = 4'd1;
    logic flush_wr_i = 0, dnr_i = 0, ovf_ie_i = 0, ovf_clr_i = 0;
    logic addr_ack_o, byte_ack_o, thr_flag_o, flush_busy_o, ovf_o, ovf_irq_o;
    logic [7:0] rd_data_o, depth_o;
    logic [3:0] level_o;

    int n_cmp = 0;
    int n_bad = 0;
    int ncyc  = 0;

    // reference model state
    logic [7:0] q[$];
    bit m_busy = 0, m_blk = 0, m_ovf = 0;

    always #2.5 clk = ~clk;

    i2c_tgt_rxq u0 (.*);

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 150000);
            finish_run();
        end
    end

    // One cycle: compare against model, advance model, clear pulses.
    task automatic tick();
        int  sz;
        bit  emp, ful, opn, psh, ovf_e;
        @(negedge clk);
        #1;
        if (rst) begin
            q.delete(); m_busy = 0; m_blk = 0; m_ovf = 0;
        end else begin
            sz  = q.size();
            emp = (sz == 0);
            ful = (sz == 8);
            opn = byte_vld_i && !m_blk && !m_busy;
            psh = opn && !ful;
            ovf_e = opn && ful;
            chk("R1", "depth",  depth_o, 8);
            chk("R11", "level", level_o, sz);
            chk(emp ? "R10" : "R11", "rd_data", rd_data_o, emp ? 0 : q[0]);
            chk((thresh_i == 0 || thresh_i >= 8) ? "R3" : "R2", "thr",
                thr_flag_o, (sz >= thresh_i) ? 1 : 0);
            chk("R4", "busy", flush_busy_o, m_busy);
            chk("R8", "ovf",  ovf_o, m_ovf);
            chk("R9", "irq",  ovf_irq_o, (m_ovf && ovf_ie_i) ? 1 : 0);
            if (wr_req_i)
                chk(emp ? "R7" : (dnr_i ? "R6" : "R5"), "addr_ack", addr_ack_o,
                    (emp || !dnr_i) ? 1 : 0);
            if (byte_vld_i)
                chk(m_busy ? "R12" : (m_blk ? "R5" : (ful ? "R8" : "R7")), "byte_ack",
                    byte_ack_o, psh ? 1 : 0);
            // advance
            if (m_busy) q.delete();
            else begin
                if (rd_i && !emp) void'(q.pop_front());
                if (psh) q.push_back(byte_i);
            end
            if (ovf_e) m_ovf = 1;
            else if (ovf_clr_i) m_ovf = 0;
            if (wr_req_i) m_blk = !emp;
            else if (stop_i) m_blk = 0;
            m_busy = flush_wr_i;
        end
        @(posedge clk);
        #1;
        wr_req_i = 0; stop_i = 0; byte_vld_i = 0; rd_i = 0;
        flush_wr_i = 0; ovf_clr_i = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_vld_i = 1; byte_i = b; tick();
    endtask

    task automatic rd_one();
        rd_i = 1; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        #1;
        // R1 reset state
        chk("R1", "reset_level", level_o, 0);
        chk("R9", "reset_irq", ovf_irq_o, 0);
        tick();

        // R7 empty queue: address and data accepted, both policies
        dnr_i = 1; wr_req_i = 1; tick();
        send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
        stop_i = 1; tick();
        chk("R2", "level3", level_o, 3);

        // R2/R3 threshold sweep
        for (int t = 0; t < 16; t++) begin thresh_i = 4'(t); tick(); end
        thresh_i = 4'd1;

        // R6 non-empty, dnr=1: address refused
        dnr_i = 1; wr_req_i = 1; tick();
        send_byte(8'h11); stop_i = 1; tick();
        // R5 non-empty, dnr=0: address accepted, data refused
        dnr_i = 0; wr_req_i = 1; tick();
        send_byte(8'h22); send_byte(8'h33); stop_i = 1; tick();
        chk("R5", "level_after_refuse", level_o, 3);

        // R11 order, then R10 empty read
        rd_one(); rd_one(); rd_one();
        rd_one(); rd_one();
        chk("R10", "empty_level", level_o, 0);
        chk("R10", "empty_data", rd_data_o, 0);

        // R8 overflow: fill then push past it
        ovf_ie_i = 0; wr_req_i = 1; tick();
        for (int i = 0; i < 10; i++) send_byte(8'(8'h40 + i));
        chk("R8", "ovf_set", ovf_o, 1);
        chk("R9", "irq_masked", ovf_irq_o, 0);
        ovf_ie_i = 1; tick();
        tick();
        ovf_clr_i = 1; tick();
        chk("R8", "ovf_cleared", ovf_o, 0);
        thresh_i = 4'd8; tick();

        // R12 flush with byte and read in busy cycle; R4 zero write no effect
        flush_wr_i = 0; tick();
        flush_wr_i = 1; tick();
        byte_vld_i = 1; byte_i = 8'h77; rd_i = 1; tick();
        chk("R4", "flushed", level_o, 0);
        chk("R12", "no_ovf", ovf_o, 0);
        stop_i = 1; tick();

        // randomized mix
        for (int i = 0; i < 20000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            wr_req_i   = (r < 4);
            stop_i     = (r >= 4 && r < 8);
            byte_vld_i = ($urandom_range(0, 99) < 45);
            byte_i     = 8'($urandom);
            rd_i       = ($urandom_range(0, 99) < ((i / 500) % 2 ? 15 : 45));
            flush_wr_i = ($urandom_range(0, 199) == 0);
            ovf_clr_i  = ($urandom_range(0, 49) == 0);
            if ($urandom_range(0, 63) == 0) thresh_i = 4'($urandom);
            if ($urandom_range(0, 31) == 0) dnr_i = ~dnr_i;
            if ($urandom_range(0, 31) == 0) ovf_ie_i = ~ovf_ie_i;
            tick();
        end
        finish_run();
    end
endmodule